// File: doc/BRIEF.md
# Descriptor-Driven Multichannel DMA Sequencer

This block is an eight-channel memory-to-memory transfer engine. Every channel owns two control descriptors, a primary one and an alternate one. Each descriptor holds an end address for the source, an end address for the destination and a 32-bit control word. The descriptors reach the engine as flat input ports. The engine updates a descriptor by raising a one-cycle write-back strobe, and the surrounding memory or register store applies the new control word. A channel starts work after it has been enabled and has received a request, either a software pulse or a peripheral level. A fixed-priority arbiter chooses among the channels that are both enabled and pending. The winner then moves items one at a time through a single read/write memory port until its arbitration period ends or the whole cycle is complete.

The control word selects the cycle type, the item count, the item size, the address steps and the arbitration period. Addresses are formed backwards from the end pointers, so a partly finished cycle can resume later from the count that was written back. When a cycle completes, the engine sets a sticky done flag for that channel. Basic and auto-request cycles disable the channel at completion. A ping-pong cycle instead hands over to the other descriptor of the same channel and keeps the channel enabled.

The memory port follows valid/ready rules. `mem_req` is the valid and `mem_gnt` is the ready. While a request waits for its grant, the address, the direction, the size and the write data stay constant. A transfer takes place on a clock edge where both `mem_req` and `mem_gnt` are high. Read data must be presented on `mem_rdata` in the cycle that follows the read handshake. The memory may hold off the engine for any number of cycles.

Top module: `dma_seq`

## Requirements
- R1: After reset, every channel is disabled, no request is pending, no done flag is set, every channel selects its primary descriptor, and `mem_req` and `wb_valid` are low.
- R2: When several enabled channels have pending requests, the lowest-numbered channel is served first. Channel 0 has the highest priority.
- R3: Control word bits [13:4] hold N-1, and a cycle moves N items. Item k (k = 0..N-1) is read from src_end - (N-1-k)*W and written to dst_end - (N-1-k)*W. The size field in bits [25:24] gives W: 00 is a byte, 01 a halfword and 10 a word. Item data is right-aligned on `mem_rdata` and `mem_wdata`.
- R4: The source step code sits in bits [27:26] and the destination step code in bits [31:30]. Step code 11 keeps that side's address fixed at its end pointer; any other step code advances by W.
- R5: Bits [17:14] hold P. After 2^P items the engine writes back the control word with bits [13:4] set to the remaining count minus 1 and then arbitrates again. A higher-priority pending channel can take over at that point. P of 10 or more means the whole cycle runs as one period.
- R6: Cycle type code 001 (basic) needs a new request for every arbitration period. Code 010 (auto-request) requests itself again after each period until the cycle is complete.
- R7: When a cycle completes, the engine writes back the control word with bits [13:4] and [2:0] cleared and sets that channel's done flag. Basic and auto-request channels are then disabled.
- R8: Code 011 (ping-pong): when a cycle completes, the channel stays enabled and changes its selected descriptor (primary to alternate or alternate to primary). The next request runs the other descriptor.
- R9: If a loaded control word has cycle type 000 or 100 to 111, the channel is disabled. It then performs no memory access, no write-back and no done flag.
- R10: A done flag stays set until its `done_clr` bit is pulsed.
- R11: While `mem_req` is high and `mem_gnt` is low, `mem_addr`, `mem_we` and `mem_wdata` hold. Read data is taken one cycle after the read handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | NCH | Software request pulse per channel |
| per_req | input | NCH | Peripheral request level per channel |
| en_set | input | NCH | Enable pulse per channel |
| done_clr | input | NCH | Clears the done flag per channel |
| pri_src_end | input | NCH*AW | Primary source end pointers |
| pri_dst_end | input | NCH*AW | Primary destination end pointers |
| pri_ctrl | input | NCH*32 | Primary control words |
| alt_src_end | input | NCH*AW | Alternate source end pointers |
| alt_dst_end | input | NCH*AW | Alternate destination end pointers |
| alt_ctrl | input | NCH*32 | Alternate control words |
| wb_valid | output | 1 | Control word write-back strobe |
| wb_ch | output | CHW | Channel being written back |
| wb_alt | output | 1 | Write-back targets the alternate descriptor |
| wb_ctrl | output | 32 | Updated control word |
| mem_req | output | 1 | Memory transfer valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Item size code |
| mem_wdata | output | DW | Write data, right-aligned |
| mem_gnt | input | 1 | Memory ready |
| mem_rdata | input | DW | Read data, one cycle after the read handshake |
| ch_enabled | output | NCH | Channel enable state |
| ch_alt | output | NCH | Channel currently selects the alternate descriptor |
| done_flag | output | NCH | Sticky completion flags |

## Verification
The main sweep runs a basic cycle for every item size, for item counts of 1, 2 and 5, and for three step patterns: both sides advancing, the source fixed, and the destination fixed. The expected destination image is computed from the address formula. This separates correct backward addressing from off-by-one counts, wrong size scaling, and step codes that are ignored or swapped. The memory grants follow a pseudo-random pattern, so back-pressure occurs throughout the sweep.

Separate scenarios cover the remaining behaviour. One starts two channels at once to check priority. One lets a short channel interrupt a long auto-request cycle at a period boundary. One shows that a basic cycle stops after one period until it gets another request. One runs a ping-pong chain through both descriptors until a stop code is reached. One tries every stop code, and a final check confirms that the done flag stays set.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int CTRL_W = 32;
  localparam int CNT_W  = 10;
  localparam int RP_W   = 4;

  localparam logic [2:0] CY_STOP  = 3'b000;
  localparam logic [2:0] CY_BASIC = 3'b001;
  localparam logic [2:0] CY_AUTO  = 3'b010;
  localparam logic [2:0] CY_PING  = 3'b011;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RD, S_RDW, S_WR, S_WB} seq_state_e;

  function automatic logic [2:0] cyc_of(input logic [CTRL_W-1:0] c);
    return c[2:0];
  endfunction
  function automatic logic [CNT_W-1:0] cnt_of(input logic [CTRL_W-1:0] c);
    return c[13:4];
  endfunction
  function automatic logic [RP_W-1:0] rp_of(input logic [CTRL_W-1:0] c);
    return c[17:14];
  endfunction
  function automatic logic [1:0] size_of(input logic [CTRL_W-1:0] c);
    return c[25:24];
  endfunction
  function automatic logic [1:0] sstep_of(input logic [CTRL_W-1:0] c);
    return c[27:26];
  endfunction
  function automatic logic [1:0] dstep_of(input logic [CTRL_W-1:0] c);
    return c[31:30];
  endfunction
  function automatic logic runnable(input logic [2:0] cy);
    return (cy == CY_BASIC) || (cy == CY_AUTO) || (cy == CY_PING);
  endfunction
  function automatic logic [CTRL_W-1:0] with_cnt(input logic [CTRL_W-1:0] c,
                                                 input logic [CNT_W-1:0] n);
    logic [CTRL_W-1:0] r;
    r = c;
    r[13:4] = n;
    return r;
  endfunction
  function automatic logic [CTRL_W-1:0] retired(input logic [CTRL_W-1:0] c);
    logic [CTRL_W-1:0] r;
    r = c;
    r[13:4] = '0;
    r[2:0] = CY_STOP;
    return r;
  endfunction
endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [NCH-1:0] win_oh,
  output logic [CHW-1:0] win_idx
);
  always_comb begin
    any = |req;
    win_oh = '0;
    win_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) begin
        win_oh = NCH'(1) << i;
        win_idx = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 16,
  parameter int CW = 10
) (
  input  logic [AW-1:0] end_ptr,
  input  logic [CW-1:0] left,
  input  logic [1:0]    size,
  input  logic [1:0]    step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] span;
  always_comb begin
    span = AW'(left) << size;
    addr = (step == 2'b11) ? end_ptr : end_ptr - span;
  end
endmodule

// File: rtl/dma_chan_state.sv
module dma_chan_state #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sw_req,
  input  logic [NCH-1:0] per_req,
  input  logic [NCH-1:0] en_set,
  input  logic [NCH-1:0] done_clr,
  input  logic [NCH-1:0] grant_ev,
  input  logic [NCH-1:0] dis_ev,
  input  logic [NCH-1:0] done_ev,
  input  logic [NCH-1:0] flip_ev,
  input  logic [NCH-1:0] rereq_ev,
  output logic [NCH-1:0] eligible,
  output logic [NCH-1:0] enabled,
  output logic [NCH-1:0] alt_sel,
  output logic [NCH-1:0] done
);
  logic [NCH-1:0] pend_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        enabled[i] <= 1'b0;
        pend_q[i]  <= 1'b0;
        alt_sel[i] <= 1'b0;
        done[i]    <= 1'b0;
      end else begin
        if (grant_ev[i]) pend_q[i] <= 1'b0;
        if (dis_ev[i]) begin
          enabled[i] <= 1'b0;
          pend_q[i]  <= 1'b0;
        end
        if (en_set[i]) enabled[i] <= 1'b1;
        if (sw_req[i] || per_req[i] || rereq_ev[i]) pend_q[i] <= 1'b1;
        if (flip_ev[i]) alt_sel[i] <= ~alt_sel[i];
        if (done_clr[i]) done[i] <= 1'b0;
        if (done_ev[i]) done[i] <= 1'b1;
      end
    end

    // R10: a done flag survives every cycle without a clear
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done[i] && !done_clr[i]) |=> done[i]);
  end

  assign eligible = pend_q & enabled;
endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int NCH = 8,
  parameter int AW  = 16,
  parameter int DW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW  = dma_pkg::CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    sw_req,
  input  logic [NCH-1:0]    per_req,
  input  logic [NCH-1:0]    en_set,
  input  logic [NCH-1:0]    done_clr,
  input  logic [NCH*AW-1:0] pri_src_end,
  input  logic [NCH*AW-1:0] pri_dst_end,
  input  logic [NCH*CW-1:0] pri_ctrl,
  input  logic [NCH*AW-1:0] alt_src_end,
  input  logic [NCH*AW-1:0] alt_dst_end,
  input  logic [NCH*CW-1:0] alt_ctrl,
  output logic              wb_valid,
  output logic [CHW-1:0]    wb_ch,
  output logic              wb_alt,
  output logic [CW-1:0]     wb_ctrl,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata,
  output logic [NCH-1:0]    ch_enabled,
  output logic [NCH-1:0]    ch_alt,
  output logic [NCH-1:0]    done_flag
);
  import dma_pkg::*;

  seq_state_e       st;
  logic [CHW-1:0]   ch_q;
  logic             alt_q;
  logic [AW-1:0]    src_q, dst_q, saddr, daddr;
  logic [CW-1:0]    ctl_q, wbc_q, sel_ctl;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W:0]   pcnt_q, plen;
  logic [RP_W-1:0]  shamt;
  logic [DW-1:0]    dat_q;
  logic             fin_q, stop_now, period_end;
  logic [NCH-1:0]   elig, win_oh, ch_oh;
  logic [NCH-1:0]   grant_ev, dis_ev, done_ev, flip_ev, rereq_ev;
  logic             any_elig;
  logic [CHW-1:0]   win_idx;

  dma_prio_arb #(.NCH(NCH)) u_arb (
    .req(elig), .any(any_elig), .win_oh(win_oh), .win_idx(win_idx));

  dma_chan_state #(.NCH(NCH)) u_chs (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .per_req(per_req),
    .en_set(en_set), .done_clr(done_clr), .grant_ev(grant_ev),
    .dis_ev(dis_ev), .done_ev(done_ev), .flip_ev(flip_ev),
    .rereq_ev(rereq_ev), .eligible(elig), .enabled(ch_enabled),
    .alt_sel(ch_alt), .done(done_flag));

  dma_addr_gen #(.AW(AW), .CW(CNT_W)) u_src_ag (
    .end_ptr(src_q), .left(rem_q), .size(size_of(ctl_q)),
    .step(sstep_of(ctl_q)), .addr(saddr));

  dma_addr_gen #(.AW(AW), .CW(CNT_W)) u_dst_ag (
    .end_ptr(dst_q), .left(rem_q), .size(size_of(ctl_q)),
    .step(dstep_of(ctl_q)), .addr(daddr));

  assign sel_ctl  = ch_alt[ch_q] ? alt_ctrl[ch_q*CW +: CW] : pri_ctrl[ch_q*CW +: CW];
  assign stop_now = !runnable(cyc_of(sel_ctl));
  assign ch_oh    = NCH'(1) << ch_q;

  always_comb begin
    shamt = (rp_of(ctl_q) > RP_W'(CNT_W)) ? RP_W'(CNT_W) : rp_of(ctl_q);
    plen = (CNT_W+1)'(1) << shamt;
    period_end = (pcnt_q + (CNT_W+1)'(1)) == plen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ch_q <= '0;
      alt_q <= 1'b0;
      src_q <= '0;
      dst_q <= '0;
      ctl_q <= '0;
      wbc_q <= '0;
      rem_q <= '0;
      pcnt_q <= '0;
      dat_q <= '0;
      fin_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (any_elig) begin
          ch_q <= win_idx;
          st <= S_LOAD;
        end
        S_LOAD: begin
          if (stop_now) st <= S_IDLE;
          else begin
            alt_q  <= ch_alt[ch_q];
            ctl_q  <= sel_ctl;
            src_q  <= ch_alt[ch_q] ? alt_src_end[ch_q*AW +: AW] : pri_src_end[ch_q*AW +: AW];
            dst_q  <= ch_alt[ch_q] ? alt_dst_end[ch_q*AW +: AW] : pri_dst_end[ch_q*AW +: AW];
            rem_q  <= cnt_of(sel_ctl);
            pcnt_q <= '0;
            st <= S_RD;
          end
        end
        S_RD:  if (mem_gnt) st <= S_RDW;
        S_RDW: begin
          dat_q <= mem_rdata;
          st <= S_WR;
        end
        S_WR: if (mem_gnt) begin
          if (rem_q == '0) begin
            fin_q <= 1'b1;
            wbc_q <= retired(ctl_q);
            st <= S_WB;
          end else if (period_end) begin
            fin_q <= 1'b0;
            wbc_q <= with_cnt(ctl_q, rem_q - CNT_W'(1));
            st <= S_WB;
          end else begin
            rem_q <= rem_q - CNT_W'(1);
            pcnt_q <= pcnt_q + (CNT_W+1)'(1);
            st <= S_RD;
          end
        end
        S_WB: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    grant_ev = (st == S_IDLE && any_elig) ? win_oh : '0;
    dis_ev   = ((st == S_LOAD && stop_now) ||
                (st == S_WB && fin_q && cyc_of(ctl_q) != CY_PING)) ? ch_oh : '0;
    done_ev  = (st == S_WB && fin_q) ? ch_oh : '0;
    flip_ev  = (st == S_WB && fin_q && cyc_of(ctl_q) == CY_PING) ? ch_oh : '0;
    rereq_ev = (st == S_WB && !fin_q && cyc_of(ctl_q) == CY_AUTO) ? ch_oh : '0;
  end

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = (st == S_WR) ? daddr : saddr;
  assign mem_size  = size_of(ctl_q);
  assign mem_wdata = dat_q;
  assign wb_valid  = (st == S_WB);
  assign wb_ch     = ch_q;
  assign wb_alt    = alt_q;
  assign wb_ctrl   = wbc_q;

  // R11: a waiting request keeps its address, direction and data
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R2: the selected channel has no lower-numbered eligible rival
  p_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && any_elig) |=> (($past(elig) & ((NCH'(1) << ch_q) - NCH'(1))) == '0));

  // R7: a write-back always follows an accepted write
  p_wb_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(mem_req && mem_gnt && mem_we));

  // R9: a stop code never leads to a memory access
  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && stop_now) |=> !mem_req);
endmodule

// File: tb/test_dma_seq.sv
`timescale 1ns/1ps
module test_dma_seq;
  localparam int NCH = 8;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] sw_req, per_req, en_set, done_clr;
  logic [NCH*AW-1:0] pse_f, pde_f, ase_f, ade_f;
  logic [NCH*32-1:0] pct_f, act_f;
  logic wb_valid, wb_alt, mem_req, mem_we, mem_gnt;
  logic [2:0] wb_ch;
  logic [31:0] wb_ctrl;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [NCH-1:0] ch_enabled, ch_alt, done_flag;

  logic [15:0] psrc[NCH], pdst[NCH], asrc[NCH], adst[NCH];
  logic [31:0] pctl[NCH], actl[NCH];
  logic [7:0] mem[0:1023];
  int wr_cnt = 0, rd_cnt = 0;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] lfsr = 8'h5B;

  always #2.5 clk = ~clk;

  dma_seq i_dma_seq (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .per_req(per_req),
    .en_set(en_set), .done_clr(done_clr),
    .pri_src_end(pse_f), .pri_dst_end(pde_f), .pri_ctrl(pct_f),
    .alt_src_end(ase_f), .alt_dst_end(ade_f), .alt_ctrl(act_f),
    .wb_valid(wb_valid), .wb_ch(wb_ch), .wb_alt(wb_alt), .wb_ctrl(wb_ctrl),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .ch_enabled(ch_enabled), .ch_alt(ch_alt),
    .done_flag(done_flag));

  always_comb
    for (int i = 0; i < NCH; i++) begin
      pse_f[i*AW +: AW] = psrc[i];
      pde_f[i*AW +: AW] = pdst[i];
      ase_f[i*AW +: AW] = asrc[i];
      ade_f[i*AW +: AW] = adst[i];
      pct_f[i*32 +: 32] = pctl[i];
      act_f[i*32 +: 32] = actl[i];
    end

  function automatic logic [31:0] rd_item(input logic [15:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int b = 0; b < 4; b++)
      if (b < (1 << sz)) v[8*b +: 8] = mem[10'(a + 16'(b))];
    return v;
  endfunction

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_gnt <= lfsr[0] | lfsr[1];
  end

  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (b < (1 << mem_size)) mem[10'(mem_addr + 16'(b))] <= mem_wdata[8*b +: 8];
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= rd_item(mem_addr, mem_size);
        rd_cnt <= rd_cnt + 1;
      end
    end
    if (wb_valid) begin
      if (wb_alt) actl[wb_ch] <= wb_ctrl;
      else pctl[wb_ch] <= wb_ctrl;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input logic [2:0] cy, input int n, input logic [3:0] r,
                                          input logic [1:0] sz, input logic [1:0] si, input logic [1:0] di);
    return {di, sz, si, sz, 6'b0, r, 10'(n - 1), 1'b0, cy};
  endfunction

  function automatic logic [31:0] itemv(input int n, input int sz, input int i);
    logic [31:0] m = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    return (32'hC3A5_0000 + 32'(n << 8) + 32'(i * 17) + 32'(sz)) & m;
  endfunction

  task automatic wr_item(input logic [15:0] a, input int sz, input logic [31:0] v);
    for (int b = 0; b < (1 << sz); b++) mem[10'(a + 16'(b))] = v[8*b +: 8];
  endtask

  task automatic fill(input logic [15:0] base, input int n, input int sz);
    for (int i = 0; i < n; i++) wr_item(base + 16'(i << sz), sz, itemv(n, sz, i));
  endtask

  task automatic clear_dst();
    for (int a = 16'h200; a < 16'h300; a++) mem[a] = 8'h00;
  endtask

  task automatic pulse(input logic [NCH-1:0] s, input logic [NCH-1:0] p,
                       input logic [NCH-1:0] e, input logic [NCH-1:0] c);
    sw_req = s; per_req = p; en_set = e; done_clr = c;
    @(negedge clk);
    sw_req = '0; per_req = '0; en_set = '0; done_clr = '0;
  endtask

  task automatic wait_done(input int c);
    for (int k = 0; k < 3000 && !done_flag[c]; k++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int w0, bad;
    rst_n = 1'b0;
    sw_req = '0; per_req = '0; en_set = '0; done_clr = '0;
    mem_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      psrc[i] = '0; pdst[i] = '0; asrc[i] = '0; adst[i] = '0; pctl[i] = '0; actl[i] = '0;
    end
    for (int a = 0; a < 1024; a++) mem[a] = 8'h00;
    idle(5);
    rst_n = 1'b1;
    idle(1);
    chk("R1 enabled", ch_enabled, 0);
    chk("R1 done", done_flag, 0);
    chk("R1 alt", ch_alt, 0);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 wb_valid", wb_valid, 0);

    // R3 R4 R7 R11 sweep: size x count x step pattern, basic cycles
    for (int sz = 0; sz < 3; sz++)
      for (int ni = 0; ni < 3; ni++)
        for (int md = 0; md < 3; md++) begin
          int n, c;
          logic [31:0] exp;
          n = (ni == 0) ? 1 : (ni == 1) ? 2 : 5;
          c = sz + md;
          clear_dst();
          fill(16'h100, n, sz);
          psrc[c] = 16'h100 + 16'((n - 1) << sz);
          pdst[c] = 16'h200 + 16'((n - 1) << sz);
          pctl[c] = mk_ctrl(3'b001, n, 4'hF, 2'(sz), (md == 1) ? 2'b11 : 2'(sz), (md == 2) ? 2'b11 : 2'(sz));
          w0 = wr_cnt;
          pulse('0, '0, NCH'(1) << c, '0);
          pulse(NCH'(1) << c, '0, '0, '0);
          wait_done(c);
          idle(2);
          for (int i = 0; i < n; i++) begin
            if (md == 0) exp = itemv(n, sz, i);
            else if (md == 1) exp = itemv(n, sz, n - 1);
            else exp = (i == n - 1) ? itemv(n, sz, n - 1) : 32'h0;
            chk($sformatf("R3 R4 data sz=%0d n=%0d md=%0d i=%0d", sz, n, md, i),
                rd_item(16'h200 + 16'(i << sz), 2'(sz)), exp);
          end
          chk("R3 transfer count", wr_cnt - w0, n);
          chk("R11 reads match writes", rd_cnt, wr_cnt);
          chk("R7 done set", done_flag[c], 1);
          chk("R7 channel disabled", ch_enabled[c], 0);
          chk("R7 written-back count/type", {pctl[c][13:4], pctl[c][2:0]}, 0);
          pulse('0, '0, '0, NCH'(1) << c);
        end

    // R2: channels 2 and 5 requested together
    clear_dst();
    fill(16'h100, 4, 2);
    psrc[2] = 16'h10C; pdst[2] = 16'h20C; pctl[2] = mk_ctrl(3'b001, 4, 4'hF, 2, 2, 2);
    psrc[5] = 16'h10C; pdst[5] = 16'h28C; pctl[5] = mk_ctrl(3'b001, 4, 4'hF, 2, 2, 2);
    pulse('0, '0, 8'h24, '0);
    pulse(8'h24, '0, '0, '0);
    wait_done(2);
    chk("R2 channel 5 waits for channel 2", done_flag[5], 0);
    wait_done(5);
    chk("R2 channel 5 completes", done_flag[5], 1);
    chk("R2 data ch5", rd_item(16'h28C, 2), itemv(4, 2, 3));
    pulse('0, '0, '0, 8'h24);

    // R5 R6: auto-request ch6 with period 2, interrupted by ch1
    clear_dst();
    fill(16'h100, 12, 0);
    wr_item(16'h180, 0, 32'h77);
    psrc[6] = 16'h10B; pdst[6] = 16'h20B; pctl[6] = mk_ctrl(3'b010, 12, 4'd1, 0, 0, 0);
    psrc[1] = 16'h180; pdst[1] = 16'h2C0; pctl[1] = mk_ctrl(3'b001, 1, 4'hF, 0, 0, 0);
    pulse('0, '0, 8'h42, '0);
    pulse(8'h40, '0, '0, '0);
    idle(6);
    pulse(8'h02, '0, '0, '0);
    wait_done(1);
    chk("R5 ch1 overtakes ch6 at period end", done_flag[6], 0);
    chk("R5 ch1 data", rd_item(16'h2C0, 0), 32'h77);
    wait_done(6);
    idle(2);
    bad = 0;
    for (int i = 0; i < 12; i++) if (rd_item(16'h200 + 16'(i), 0) != itemv(12, 0, i)) bad++;
    chk("R6 auto-request completes after one request", bad, 0);
    chk("R6 auto channel disabled", ch_enabled[6], 0);
    pulse('0, '0, '0, 8'h42);

    // R6 R5: basic ch7, N=8, period 2
    clear_dst();
    fill(16'h100, 8, 1);
    psrc[7] = 16'h10E; pdst[7] = 16'h20E; pctl[7] = mk_ctrl(3'b001, 8, 4'd1, 1, 1, 1);
    w0 = wr_cnt;
    pulse('0, '0, 8'h80, '0);
    pulse(8'h80, '0, '0, '0);
    idle(60);
    chk("R6 basic stops after one period", wr_cnt - w0, 2);
    chk("R5 written-back count field", pctl[7][13:4], 5);
    chk("R6 basic still enabled", ch_enabled[7], 1);
    chk("R6 basic not done", done_flag[7], 0);
    for (int k = 0; k < 3; k++) begin
      pulse('0, 8'h80, '0, '0);
      idle(60);
    end
    chk("R6 basic total transfers", wr_cnt - w0, 8);
    chk("R6 basic done", done_flag[7], 1);
    bad = 0;
    for (int i = 0; i < 8; i++) if (rd_item(16'h200 + 16'(2 * i), 1) != itemv(8, 1, i)) bad++;
    chk("R3 resumed addresses", bad, 0);

    // R10: done flag sticky then cleared
    idle(20);
    chk("R10 done sticky", done_flag[7], 1);
    pulse('0, '0, '0, 8'h80);
    idle(1);
    chk("R10 done cleared", done_flag[7], 0);

    // R8: ping-pong ch3, primary -> alternate -> primary(stop)
    clear_dst();
    fill(16'h100, 4, 2);
    psrc[3] = 16'h104; pdst[3] = 16'h204; pctl[3] = mk_ctrl(3'b011, 2, 4'hF, 2, 2, 2);
    asrc[3] = 16'h10C; adst[3] = 16'h224; actl[3] = mk_ctrl(3'b011, 2, 4'hF, 2, 2, 2);
    pulse('0, '0, 8'h08, '0);
    pulse('0, 8'h08, '0, '0);
    wait_done(3);
    idle(2);
    chk("R8 stays enabled", ch_enabled[3], 1);
    chk("R8 switched to alternate", ch_alt[3], 1);
    chk("R8 primary retired", pctl[3][2:0], 0);
    chk("R8 primary data", rd_item(16'h204, 2), itemv(4, 2, 1));
    pulse('0, '0, '0, 8'h08);
    pulse('0, 8'h08, '0, '0);
    wait_done(3);
    idle(2);
    chk("R8 alternate data", rd_item(16'h224, 2), itemv(4, 2, 3));
    chk("R8 back to primary", ch_alt[3], 0);
    chk("R8 alternate retired", actl[3][2:0], 0);
    pulse('0, '0, '0, 8'h08);
    w0 = wr_cnt;
    pulse('0, 8'h08, '0, '0);
    idle(30);
    chk("R8 R9 retired primary disables", ch_enabled[3], 0);
    chk("R9 no transfer on stop", wr_cnt - w0, 0);
    chk("R9 no done on stop", done_flag[3], 0);

    // R9: every stop code
    for (int cy = 0; cy < 8; cy++)
      if (cy == 0 || cy >= 4) begin
        pctl[4] = mk_ctrl(3'(cy), 3, 4'hF, 2, 2, 2);
        w0 = wr_cnt;
        pulse('0, '0, 8'h10, '0);
        pulse(8'h10, '0, '0, '0);
        idle(20);
        chk($sformatf("R9 code %0d disables", cy), ch_enabled[4], 0);
        chk($sformatf("R9 code %0d no transfer", cy), wr_cnt - w0, 0);
        chk($sformatf("R9 code %0d no done", cy), done_flag[4], 0);
        chk($sformatf("R9 code %0d untouched", cy), pctl[4], mk_ctrl(3'(cy), 3, 4'hF, 2, 2, 2));
      end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule